// File: doc/BRIEF.md
# Dual-Channel Serial Trim Register Controller

This block is the digital core of a two-channel, 8-bit calibration DAC. A host talks to it over a three-wire serial link: a serial clock that also clocks the block, an active-high select, and a data input. A fourth line returns data. It is driven while select is high and released (enable low) otherwise. Each channel holds two codes. The working code drives that channel's DAC code output. The stored code models the nonvolatile setting and survives a select drop.

A frame starts with a 1 start bit. After it come two address bits (A0, then A1), then a two-bit operation field, least significant bit first. A load carries eight data bits after that field, also least significant bit first. A read returns the stored code on the data output. A store copies the working code into the stored code after an emulated erase/write delay, during which a busy flag is high. Dropping select aborts any frame in progress and returns both working codes to their stored values, so a host can try new codes and discard them.

Top module: `trim_ctrl`

## Requirements
- R1: During and after synchronous reset, both working codes and both stored codes equal the parameter INIT_CODES (channel 1 in the low byte, default 0x80; channel 2 in the high byte, default 0x3C), busy is 0 and sdo is 0.
- R2: A frame is the start bit 1, then A0, A1, then operation bits O0, O1, sampled on rising edges. A1=1 is required; A0=0 addresses channel 1 and A0=1 addresses channel 2. Operation {O1,O0}=00 (load) takes eight further data bits, LSB first. The working code of the addressed channel takes the byte on the edge that samples the last data bit.
- R3: A frame with A1=0 keeps the length its operation implies but changes no code, reads back 0, and never raises busy.
- R4: Operation 01 (read) puts the stored code of the addressed channel on sdo, LSB first. Bit k is present after the (k+1)-th rising edge following the edge that samples O1. Neither working code changes.
- R5: Operation 10 (store) with prog_en high at the edge that samples O1 sets busy on that edge. Busy then stays high for exactly PROG_CYCLES rising edges. When it falls, the stored code equals the working code captured when the store was requested. Stored codes never change while busy is low.
- R6: A store with prog_en low has no effect: busy stays 0 and the stored code is unchanged.
- R7: While busy is high, a start bit is not recognised, so a load sent during that time leaves both working codes unchanged.
- R8: When select is sampled low, any frame in progress is dropped and both working codes take their stored values on that edge.
- R9: For GAP_CYCLES (default 2) rising edges after the last bit of a frame, sdi is not examined, and a 1 there is not taken as a start bit.
- R10: Operation 11 changes no working code, no stored code and no busy state.
- R11: sdo_en equals sel, and sdo is 0 except while read bits are being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high power-up reset |
| sel | input | 1 | Active-high select; low aborts frames and reverts working codes |
| sdi | input | 1 | Serial data in |
| prog_en | input | 1 | Program enable; must be high for a store to start |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Output enable for sdo (low means high impedance) |
| busy | output | 1 | High during an emulated erase/write cycle |
| dac_ch1 | output | 8 | Working code of channel 1 |
| dac_ch2 | output | 8 | Working code of channel 2 |

## Verification
A load shows on the DAC outputs directly after the edge that samples its last data bit. The select revert shows directly after the first edge that sees select low. Busy rises directly after the edge that samples the store command's last operation bit. Read data lags by one edge: bit k appears after the (k+1)-th edge that follows the operation field. The bench drives and samples on falling edges only, so each check falls half a cycle after the edge that is meant to produce it. For busy, it counts falling edges with busy high and expects exactly PROG_CYCLES of them.

// File: rtl/trim_pkg.sv
package trim_pkg;

    localparam int CODE_W   = 8;
    localparam int NUM_CH   = 2;
    localparam int HDR_BITS = 4;

    typedef logic [CODE_W-1:0]          code_t;
    typedef logic [NUM_CH-1:0][CODE_W-1:0] code_vec_t;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_READ  = 2'b01,
        OP_STORE = 2'b10,
        OP_NOP   = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        RX_HUNT,
        RX_HDR,
        RX_DATA,
        RX_READ,
        RX_GAP
    } rx_state_e;

    typedef struct packed {
        logic hit;
        logic ch;
        op_e  op;
    } hdr_t;

    // bits[0]=A0, bits[1]=A1, bits[2]=O0, bits[3]=O1
    function automatic hdr_t decode_hdr(input logic [HDR_BITS-1:0] bits);
        hdr_t d;
        d.hit = bits[1];
        d.ch  = bits[0];
        d.op  = op_e'({bits[3], bits[2]});
        return d;
    endfunction

endpackage

// File: rtl/trim_frame_rx.sv
module trim_frame_rx
    import trim_pkg::*;
#(
    parameter int GAP_CYCLES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sel,
    input  logic      sdi,
    input  logic      busy,
    input  code_vec_t stored,
    output logic      ld_stb,
    output logic      ld_ch,
    output code_t     ld_code,
    output logic      st_stb,
    output logic      st_ch,
    output logic      sdo
);

    localparam int CNT_MAX = (CODE_W > GAP_CYCLES) ? CODE_W : GAP_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX) + 1;
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] CODE_LAST = CNT_W'(CODE_W - 1);
    localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_CYCLES - 1);

    rx_state_e          state;
    logic [CNT_W-1:0]   cnt;
    logic [HDR_BITS-2:0] hdr_q;
    code_t              shreg;
    logic               cur_hit;
    logic               cur_ch;
    hdr_t               dec;

    always_comb begin
        dec     = decode_hdr({sdi, hdr_q});
        ld_code = {sdi, shreg[CODE_W-1:1]};
        ld_ch   = cur_ch;
        ld_stb  = sel && (state == RX_DATA) && (cnt == CODE_LAST) && cur_hit;
        st_ch   = dec.ch;
        st_stb  = sel && (state == RX_HDR) && (cnt == HDR_LAST)
                  && (dec.op == OP_STORE) && dec.hit;
    end

    always_ff @(posedge clk) begin
        if (rst || !sel) begin
            state   <= RX_HUNT;
            cnt     <= '0;
            hdr_q   <= '0;
            shreg   <= '0;
            cur_hit <= 1'b0;
            cur_ch  <= 1'b0;
            sdo     <= 1'b0;
        end else begin
            unique case (state)
                RX_HUNT: begin
                    sdo <= 1'b0;
                    cnt <= '0;
                    if (sdi && !busy) state <= RX_HDR;
                end
                RX_HDR: begin
                    if (cnt == HDR_LAST) begin
                        cnt     <= '0;
                        cur_hit <= dec.hit;
                        cur_ch  <= dec.ch;
                        case (dec.op)
                            OP_LOAD: state <= RX_DATA;
                            OP_READ: begin
                                state <= RX_READ;
                                shreg <= dec.hit ? stored[dec.ch] : '0;
                            end
                            default: state <= RX_GAP;
                        endcase
                    end else begin
                        hdr_q <= {sdi, hdr_q[HDR_BITS-2:1]};
                        cnt   <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    shreg <= ld_code;
                    if (cnt == CODE_LAST) begin
                        state <= RX_GAP;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_READ: begin
                    sdo   <= shreg[0];
                    shreg <= {1'b0, shreg[CODE_W-1:1]};
                    if (cnt == CODE_LAST) begin
                        state <= RX_GAP;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_GAP: begin
                    sdo <= 1'b0;
                    if (cnt == GAP_LAST) begin
                        state <= RX_HUNT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= RX_HUNT;
            endcase
        end
    end

endmodule

// File: rtl/trim_nv_store.sv
module trim_nv_store
    import trim_pkg::*;
#(
    parameter int        PROG_CYCLES = 1000,
    parameter code_vec_t INIT_CODES  = {8'h3C, 8'h80}
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      st_stb,
    input  logic      st_ch,
    input  logic      prog_en,
    input  code_vec_t working,
    output code_vec_t stored,
    output logic      busy
);

    localparam int PW = $clog2(PROG_CYCLES + 1);
    localparam logic [PW-1:0] P_LAST = PW'(PROG_CYCLES - 1);

    logic [PW-1:0] pcnt;
    code_t         snap;
    logic          pch;

    always_ff @(posedge clk) begin
        if (rst) begin
            stored <= INIT_CODES;
            busy   <= 1'b0;
            pcnt   <= '0;
            snap   <= '0;
            pch    <= 1'b0;
        end else if (busy) begin
            if (pcnt == P_LAST) begin
                stored[pch] <= snap;
                busy        <= 1'b0;
                pcnt        <= '0;
            end else begin
                pcnt <= pcnt + 1'b1;
            end
        end else if (st_stb && prog_en) begin
            busy <= 1'b1;
            pcnt <= '0;
            snap <= working[st_ch];
            pch  <= st_ch;
        end
    end

endmodule

// File: rtl/trim_work_regs.sv
module trim_work_regs
    import trim_pkg::*;
#(
    parameter code_vec_t INIT_CODES = {8'h3C, 8'h80}
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sel,
    input  logic      ld_stb,
    input  logic      ld_ch,
    input  code_t     ld_code,
    input  code_vec_t stored,
    output code_vec_t working
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        code_t w_q;
        always_ff @(posedge clk) begin
            if (rst)                            w_q <= INIT_CODES[g];
            else if (!sel)                      w_q <= stored[g];
            else if (ld_stb && ld_ch == 1'(g))  w_q <= ld_code;
        end
        assign working[g] = w_q;
    end

endmodule

// File: rtl/trim_ctrl.sv
module trim_ctrl
    import trim_pkg::*;
#(
    parameter int        PROG_CYCLES = 1000,
    parameter int        GAP_CYCLES  = 2,
    parameter code_vec_t INIT_CODES  = {8'h3C, 8'h80}
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel,
    input  logic       sdi,
    input  logic       prog_en,
    output logic       sdo,
    output logic       sdo_en,
    output logic       busy,
    output logic [7:0] dac_ch1,
    output logic [7:0] dac_ch2
);

    code_vec_t stored_q;
    code_vec_t working_q;
    logic      ld_stb, ld_ch, st_stb, st_ch;
    code_t     ld_code;

    trim_frame_rx #(.GAP_CYCLES(GAP_CYCLES)) u_rx (
        .clk(clk), .rst(rst), .sel(sel), .sdi(sdi), .busy(busy),
        .stored(stored_q), .ld_stb(ld_stb), .ld_ch(ld_ch), .ld_code(ld_code),
        .st_stb(st_stb), .st_ch(st_ch), .sdo(sdo)
    );

    trim_nv_store #(.PROG_CYCLES(PROG_CYCLES), .INIT_CODES(INIT_CODES)) u_nv (
        .clk(clk), .rst(rst), .st_stb(st_stb), .st_ch(st_ch),
        .prog_en(prog_en), .working(working_q), .stored(stored_q), .busy(busy)
    );

    trim_work_regs #(.INIT_CODES(INIT_CODES)) u_work (
        .clk(clk), .rst(rst), .sel(sel), .ld_stb(ld_stb), .ld_ch(ld_ch),
        .ld_code(ld_code), .stored(stored_q), .working(working_q)
    );

    assign sdo_en  = sel;
    assign dac_ch1 = working_q[0];
    assign dac_ch2 = working_q[1];

endmodule

// File: rtl/trim_ctrl_chk.sv
module trim_ctrl_chk
    import trim_pkg::*;
#(
    parameter int PROG_CYCLES = 1000
) (
    input logic       clk,
    input logic       rst,
    input logic       sel,
    input logic       prog_en,
    input logic       busy,
    input logic [7:0] dac_ch1,
    input logic [7:0] dac_ch2,
    input code_vec_t  stored
);

    logic [31:0] busy_len;

    always_ff @(posedge clk) begin
        if (rst)       busy_len <= '0;
        else if (busy) busy_len <= busy_len + 1'b1;
        else           busy_len <= '0;
    end

    assert_revert_R8: assert property (@(posedge clk) disable iff (rst)
        !sel |=> ({dac_ch2, dac_ch1} == $past(stored)));

    assert_nv_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(stored));

    assert_busy_len_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_len == 32'(PROG_CYCLES)));

    assert_prog_gate_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(prog_en));

    assert_busy_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (sel && busy) |=> $stable({dac_ch2, dac_ch1}));

endmodule

bind trim_ctrl trim_ctrl_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .sel(sel), .prog_en(prog_en), .busy(busy),
    .dac_ch1(dac_ch1), .dac_ch2(dac_ch2), .stored(stored_q)
);

// File: tb/test_trim_ctrl.sv
module test_trim_ctrl;

    localparam int PCYC = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel = 1'b0;
    logic       sdi = 1'b0;
    logic       prog_en = 1'b0;
    logic       sdo, sdo_en, busy;
    logic [7:0] dac_ch1, dac_ch2;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] mw [2];
    logic [7:0] ms [2];

    always #2 clk = ~clk;

    trim_ctrl #(.PROG_CYCLES(PCYC), .GAP_CYCLES(2), .INIT_CODES({8'h3C, 8'h80})) i_trim_ctrl (
        .clk(clk), .rst(rst), .sel(sel), .sdi(sdi), .prog_en(prog_en),
        .sdo(sdo), .sdo_en(sdo_en), .busy(busy), .dac_ch1(dac_ch1), .dac_ch2(dac_ch2)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic bitout(input logic b);
        @(negedge clk);
        sdi = b;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            sdi = 1'b0;
        end
    endtask

    task automatic hdr(input logic a0, input logic a1, input logic [1:0] op);
        bitout(1'b1); bitout(a0); bitout(a1); bitout(op[0]); bitout(op[1]);
    endtask

    task automatic check_dacs(input string req);
        chk(req, {24'h0, dac_ch1}, {24'h0, mw[0]});
        chk(req, {24'h0, dac_ch2}, {24'h0, mw[1]});
    endtask

    task automatic do_load(input int ch, input logic a1, input logic [7:0] code, input string req);
        hdr(ch[0], a1, 2'b00);
        for (int i = 0; i < 8; i++) bitout(code[i]);
        @(negedge clk);
        sdi = 1'b0;
        if (a1) mw[ch] = code;
        check_dacs(req);
        chk("R11 sdo idle", {31'h0, sdo}, 32'h0);
        idle(1);
    endtask

    task automatic do_read(input int ch, input logic a1, input string req);
        logic [7:0] e;
        e = a1 ? ms[ch] : 8'h00;
        hdr(ch[0], a1, 2'b01);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            sdi = 1'b0;
            if (k > 0) chk(req, {31'h0, sdo}, {31'h0, e[k-1]});
        end
        @(negedge clk);
        chk(req, {31'h0, sdo}, {31'h0, e[7]});
        check_dacs("R4 read keeps working");
        idle(2);
    endtask

    task automatic do_store(input int ch, input logic pe, input string req);
        int n;
        prog_en = pe;
        hdr(ch[0], 1'b1, 2'b10);
        @(negedge clk);
        sdi = 1'b0;
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
        if (pe) begin
            chk(req, n, PCYC);
            ms[ch] = mw[ch];
        end else begin
            chk(req, n, 0);
        end
        prog_en = 1'b0;
        idle(2);
    endtask

    task automatic drop_sel(input string req);
        @(negedge clk);
        sel = 1'b0;
        sdi = 1'b0;
        @(negedge clk);
        chk("R11 sdo_en low", {31'h0, sdo_en}, 32'h0);
        mw[0] = ms[0];
        mw[1] = ms[1];
        check_dacs(req);
        sel = 1'b1;
        idle(1);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        mw[0] = 8'h80; mw[1] = 8'h3C;
        ms[0] = 8'h80; ms[1] = 8'h3C;

        repeat (4) @(negedge clk);
        chk("R1 busy in reset", {31'h0, busy}, 32'h0);
        sel = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        idle(2);
        check_dacs("R1 init codes");
        chk("R1 busy", {31'h0, busy}, 32'h0);
        chk("R1 sdo", {31'h0, sdo}, 32'h0);
        chk("R11 sdo_en high", {31'h0, sdo_en}, 32'h1);

        do_read(0, 1'b1, "R4 read ch1 init");
        do_read(1, 1'b1, "R4 read ch2 init");

        do_load(0, 1'b1, 8'hA5, "R2 load ch1");
        do_load(1, 1'b1, 8'h5A, "R2 load ch2");
        do_read(0, 1'b1, "R4 read stored ch1 unchanged by load");

        do_load(1, 1'b0, 8'hFF, "R3 bad address load");
        do_read(1, 1'b0, "R3 bad address read");

        hdr(1'b0, 1'b1, 2'b11);
        idle(2);
        check_dacs("R10 nop");
        chk("R10 nop busy", {31'h0, busy}, 32'h0);

        do_store(0, 1'b0, "R6 store without enable");
        do_read(0, 1'b1, "R6 stored ch1 kept");

        do_store(0, 1'b1, "R5 store ch1 busy length");
        do_read(0, 1'b1, "R5 stored ch1 updated");

        // R7: load sent while busy is ignored
        prog_en = 1'b1;
        hdr(1'b1, 1'b1, 2'b10);
        @(negedge clk);
        sdi = 1'b0;
        prog_en = 1'b0;
        chk("R5 busy rises", {31'h0, busy}, 32'h1);
        idle(2);
        hdr(1'b0, 1'b1, 2'b00);
        for (int i = 0; i < 8; i++) bitout(1'b1);
        idle(1);
        check_dacs("R7 load during busy ignored");
        while (busy) @(negedge clk);
        ms[1] = mw[1];
        idle(2);
        check_dacs("R7 after busy");
        do_read(1, 1'b1, "R5 stored ch2 updated");

        // R8: select drop reverts, and aborts a frame
        do_load(0, 1'b1, 8'h11, "R2 load ch1 trial");
        drop_sel("R8 revert on select low");
        hdr(1'b1, 1'b1, 2'b00);
        bitout(1'b1); bitout(1'b1); bitout(1'b1);
        drop_sel("R8 abort mid-frame");
        do_load(1, 1'b1, 8'h77, "R8 frame after abort");

        // R9: ones during the gap are not start bits
        hdr(1'b0, 1'b1, 2'b11);
        bitout(1'b1); bitout(1'b0); bitout(1'b1);
        idle(20);
        check_dacs("R9 gap ignores start");

        // constrained random mix
        for (int it = 0; it < 40; it++) begin
            int op, ch;
            op = int'($urandom % 6);
            ch = int'($urandom % 2);
            case (op)
                0, 1: do_load(ch, 1'b1, 8'($urandom), "R2 random load");
                2:    do_read(ch, 1'b1, "R4 random read");
                3:    do_store(ch, 1'($urandom), "R5 R6 random store");
                4:    begin hdr(ch[0], 1'b1, 2'b11); idle(2); check_dacs("R10 random nop"); end
                default: do_load(ch, 1'b0, 8'($urandom), "R3 random bad address");
            endcase
            if (($urandom % 8) == 0) drop_sel("R8 random select drop");
        end
        do_read(0, 1'b1, "R4 final ch1");
        do_read(1, 1'b1, "R4 final ch2");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule